// File: doc/BRIEF.md
# Packet Framing Monitor

This block observes a flow-controlled link on which a producer raises `valid` and a consumer may stall it with `busy`. A beat is taken into account only on a clock edge where `valid` is high and `busy` is low; every other cycle is a stall and leaves the monitor untouched. Each accepted beat carries a two-bit type field taken from the link's 24-bit command word, and the monitor checks that beats form packets: one opening beat, any number of body beats, and one closing beat.

The monitor is a two-state machine. `ST_IDLE` means no packet is open; `ST_OPEN` means an opening beat has been seen and no closing beat yet. Transitions: `ST_IDLE` to `ST_OPEN` on an opening beat; `ST_OPEN` to `ST_IDLE` on a closing beat; `ST_OPEN` stays in `ST_OPEN` on a body beat, on an opening beat (flagged, then taken as the start of a fresh packet) and on a reserved code (flagged); `ST_IDLE` stays in `ST_IDLE` on a body or closing beat (flagged as orphan) and on a reserved code (flagged). Three sticky flags record the kind of violation, a one-cycle pulse marks each violating beat, and a wrapping counter totals the packets that closed correctly. All outputs are registered and change on the edge that accepts the beat.

Top module: `pkt_frame_mon`

## Requirements
- R1: A beat is accepted only on a rising edge with `valid`=1 and `busy`=0; on any other edge the state, flags, pulse and counter keep their values (the pulse returns to 0).
- R2: Type field `kind` encodes 2'b00 open, 2'b01 body, 2'b10 close, 2'b11 reserved; an accepted open beat in `ST_IDLE` sets `in_packet` to 1 after that edge.
- R3: An accepted close beat in `ST_OPEN` clears `in_packet` and adds one to `pkt_count`, which wraps from all ones to zero.
- R4: An accepted body or close beat in `ST_IDLE` sets `err_orphan`, leaves `in_packet` at 0 and leaves `pkt_count` unchanged.
- R5: An accepted open beat in `ST_OPEN` sets `err_start` and keeps the packet open, so a following close beat counts exactly one packet.
- R6: An accepted reserved beat sets `err_code` and leaves the state unchanged in either state.
- R7: `err_pulse` is 1 for exactly the one cycle after each edge that accepts a violating beat, and 0 otherwise.
- R8: The error flags hold until an edge with `clr_err`=1 clears them; a violation accepted on that same edge leaves its own flag set.
- R9: While `rst_n` is 0 the monitor returns to `ST_IDLE` with all flags, the pulse and the counter at 0, even with a packet open.
- R10: Any number of body beats (including none) inside an open packet raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Producer offers a beat |
| busy | input | 1 | Consumer stalls the link |
| kind | input | 2 | Beat type field from the command word |
| clr_err | input | 1 | Synchronous clear of the sticky flags |
| in_packet | output | 1 | A packet is currently open |
| err_start | output | 1 | Sticky: open beat inside an open packet |
| err_orphan | output | 1 | Sticky: body or close beat with no packet open |
| err_code | output | 1 | Sticky: reserved type code accepted |
| err_pulse | output | 1 | One-cycle mark of any violating beat |
| pkt_count | output | CNT_W (16) | Count of correctly closed packets |

## Verification
The bench builds the monitor with the default 16-bit counter, which keeps counter wrap within reach: 65,536 back-to-back open/close pairs take about 131,000 cycles, so the roll-over of R3 is driven and observed directly. The vector table interleaves stalls with every transition of both states, including a clear on the same edge as a new violation, and a directed case resets the block with a packet open.

// File: rtl/frame_mon_pkg.sv
package frame_mon_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        BT_OPEN  = 2'b00,
        BT_BODY  = 2'b01,
        BT_CLOSE = 2'b10,
        BT_RSVD  = 2'b11
    } beat_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OPEN = 1'b1
    } frame_state_e;

    typedef struct packed {
        logic start;
        logic orphan;
        logic code;
    } viol_t;

endpackage

// File: rtl/beat_classify.sv
module beat_classify
    import frame_mon_pkg::*;
(
    input  logic              valid,
    input  logic              busy,
    input  logic [KIND_W-1:0] kind,
    output logic              fire,
    output beat_e             beat
);

    always_comb begin
        fire = valid & ~busy;
        beat = beat_e'(kind);
    end

endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
    import frame_mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fire,
    input  beat_e beat,
    output viol_t viol,
    output logic  close,
    output logic  in_packet
);

    frame_state_e cur_st;
    frame_state_e nxt_st;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_st <= ST_IDLE;
        end else begin
            cur_st <= nxt_st;
        end
    end

    // transition logic
    always_comb begin
        nxt_st = cur_st;
        viol   = '0;
        close  = 1'b0;
        if (fire) begin
            unique case (cur_st)
                ST_IDLE: begin
                    unique case (beat)
                        BT_OPEN:          nxt_st = ST_OPEN;
                        BT_BODY, BT_CLOSE: viol.orphan = 1'b1;
                        BT_RSVD:          viol.code = 1'b1;
                    endcase
                end
                ST_OPEN: begin
                    unique case (beat)
                        BT_OPEN:  viol.start = 1'b1;
                        BT_BODY:  nxt_st = ST_OPEN;
                        BT_CLOSE: begin
                            nxt_st = ST_IDLE;
                            close  = 1'b1;
                        end
                        BT_RSVD:  viol.code = 1'b1;
                    endcase
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        in_packet = (cur_st == ST_OPEN);
    end

endmodule

// File: rtl/err_flags.sv
module err_flags
    import frame_mon_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  viol_t viol,
    output viol_t flags,
    output logic  pulse
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            pulse <= 1'b0;
        end else begin
            flags <= (clr ? viol_t'('0) : flags) | viol;
            pulse <= |viol;
        end
    end

endmodule

// File: rtl/pkt_counter.sv
module pkt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + ONE;
        end
    end

endmodule

// File: rtl/pkt_frame_mon.sv
module pkt_frame_mon
    import frame_mon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             busy,
    input  logic [1:0]       kind,
    input  logic             clr_err,
    output logic             in_packet,
    output logic             err_start,
    output logic             err_orphan,
    output logic             err_code,
    output logic             err_pulse,
    output logic [CNT_W-1:0] pkt_count
);

    logic  fire;
    beat_e beat;
    viol_t viol;
    viol_t flags;
    logic  close;

    beat_classify u_cls (
        .valid (valid),
        .busy  (busy),
        .kind  (kind),
        .fire  (fire),
        .beat  (beat)
    );

    frame_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .beat      (beat),
        .viol      (viol),
        .close     (close),
        .in_packet (in_packet)
    );

    err_flags u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_err),
        .viol  (viol),
        .flags (flags),
        .pulse (err_pulse)
    );

    pkt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (close),
        .count (pkt_count)
    );

    always_comb begin
        err_start  = flags.start;
        err_orphan = flags.orphan;
        err_code   = flags.code;
    end

endmodule

// File: rtl/pkt_frame_mon_chk.sv
module pkt_frame_mon_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             valid,
    input logic             busy,
    input logic [1:0]       kind,
    input logic             clr_err,
    input logic             in_packet,
    input logic             err_start,
    input logic             err_orphan,
    input logic             err_code,
    input logic             err_pulse,
    input logic [CNT_W-1:0] pkt_count
);

    logic acc;
    assign acc = valid && !busy;

    a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> ($stable(in_packet) && $stable(pkt_count) && !err_pulse));

    a_r2_open_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_packet && kind == 2'b00) |=> in_packet);

    a_r3_close_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_packet && kind == 2'b10) |=>
            (!in_packet && pkt_count == $past(pkt_count) + CNT_W'(1)));

    a_r4_orphan_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !in_packet && (kind == 2'b01 || kind == 2'b10)) |=>
            (err_orphan && err_pulse && !in_packet && $stable(pkt_count)));

    a_r5_start_resync: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && in_packet && kind == 2'b00) |=> (err_start && in_packet));

    a_r6_code_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && kind == 2'b11) |=> (err_code && $stable(in_packet)));

    a_r7_pulse_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (err_start || err_orphan || err_code));

    a_r8_sticky_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        (err_orphan && !clr_err) |=> err_orphan);

    a_r8_sticky_start: assert property (@(posedge clk) disable iff (!rst_n)
        (err_start && !clr_err) |=> err_start);

endmodule

bind pkt_frame_mon pkt_frame_mon_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (valid),
    .busy       (busy),
    .kind       (kind),
    .clr_err    (clr_err),
    .in_packet  (in_packet),
    .err_start  (err_start),
    .err_orphan (err_orphan),
    .err_code   (err_code),
    .err_pulse  (err_pulse),
    .pkt_count  (pkt_count)
);

// File: tb/pkt_frame_mon_test.sv
`timescale 1ns/1ps
module pkt_frame_mon_test;

    localparam int CNT_W = 16;
    localparam int NV    = 23;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid = 1'b0;
    logic             busy = 1'b0;
    logic [1:0]       kind = 2'b00;
    logic             clr_err = 1'b0;
    logic             in_packet, err_start, err_orphan, err_code, err_pulse;
    logic [CNT_W-1:0] pkt_count;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pkt_frame_mon #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .busy(busy), .kind(kind),
        .clr_err(clr_err), .in_packet(in_packet), .err_start(err_start),
        .err_orphan(err_orphan), .err_code(err_code), .err_pulse(err_pulse),
        .pkt_count(pkt_count)
    );

    // [17]valid [16]busy [15:14]kind [13]clr | [12]in_packet [11]start [10]orphan [9]code [8]pulse [7:0]count
    localparam logic [17:0] VEC [NV] = '{
        18'b1_0_00_0_1_000_0_00000000, // 0  open
        18'b1_1_10_0_1_000_0_00000000, // 1  stalled close
        18'b0_0_10_0_1_000_0_00000000, // 2  no valid
        18'b1_0_01_0_1_000_0_00000000, // 3  body
        18'b1_0_01_0_1_000_0_00000000, // 4  body
        18'b1_0_10_0_0_000_0_00000001, // 5  close
        18'b1_0_00_0_1_000_0_00000001, // 6  open
        18'b1_0_10_0_0_000_0_00000010, // 7  close, no body
        18'b1_0_01_0_0_010_1_00000010, // 8  orphan body
        18'b0_0_00_0_0_010_0_00000010, // 9  idle, pulse drops
        18'b1_0_10_0_0_010_1_00000010, // 10 orphan close
        18'b0_0_00_1_0_000_0_00000010, // 11 clear
        18'b1_0_00_0_1_000_0_00000010, // 12 open
        18'b1_0_01_0_1_000_0_00000010, // 13 body
        18'b1_0_00_0_1_100_1_00000010, // 14 open inside packet
        18'b1_0_10_0_0_100_0_00000011, // 15 close after resync
        18'b1_0_11_0_0_101_1_00000011, // 16 reserved in idle
        18'b1_0_00_0_1_101_0_00000011, // 17 open
        18'b1_0_11_0_1_101_1_00000011, // 18 reserved in packet
        18'b1_0_10_0_0_101_0_00000100, // 19 close
        18'b1_0_01_1_0_010_1_00000100, // 20 clear with orphan
        18'b0_0_00_0_0_010_0_00000100, // 21 idle
        18'b1_1_11_0_0_010_0_00000100  // 22 stalled reserved
    };

    localparam string TAG [NV] = '{
        "R2", "R1", "R1", "R10", "R10", "R3", "R2", "R10", "R4", "R7",
        "R4", "R8", "R2", "R10", "R5", "R5", "R6", "R2", "R6", "R6",
        "R8", "R7", "R1"
    };

    function automatic logic [20:0] observed();
        return {in_packet, err_start, err_orphan, err_code, err_pulse, pkt_count};
    endfunction

    task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic b, input logic [1:0] k, input logic c);
        valid = v; busy = b; kind = k; clr_err = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", observed(), 21'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][17], VEC[i][16], VEC[i][15:14], VEC[i][13]);
            check(TAG[i], observed(), {VEC[i][12:8], 8'h00, VEC[i][7:0]});
        end

        // R9: reset with a packet open and flags set
        drive(1'b1, 1'b0, 2'b00, 1'b0);
        check("R2", {20'h0, in_packet}, 21'h1);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, 2'b00, 1'b0);
        check("R9", observed(), 21'h0);
        rst_n = 1'b1;

        // R3: counter wrap
        for (int p = 0; p < 65535; p++) begin
            drive(1'b1, 1'b0, 2'b00, 1'b0);
            drive(1'b1, 1'b0, 2'b10, 1'b0);
        end
        check("R3", observed(), {5'b00000, 16'hFFFF});
        drive(1'b1, 1'b0, 2'b00, 1'b0);
        drive(1'b1, 1'b0, 2'b10, 1'b0);
        check("R3", observed(), {5'b00000, 16'h0000});

        finish_run();
    end

endmodule